// File: doc/BRIEF.md
# Configuration Space Register Target

This block sits on the peripheral side of a multiplexed address/data bus and
serves the 256-byte configuration space of one function. A bus front end turns
each bus transaction into a single-clock request: a select strobe, a four-bit
command, a 32-bit address, four active-high byte enables and write data. The
block answers configuration reads and writes, and interrupt-acknowledge cycles.
The front end takes the read result one clock later.

Identification comes from elaboration parameters and cannot be written. The
fixed fields are a 16-bit maker code, a 16-bit model code and a 24-bit class
code. Software writes up to six 32-bit base-address registers and an 8-bit
interrupt vector during start-up. An interrupt-acknowledge cycle returns the
stored vector without any address decode.

Top module: `cfg_space_target`

## Requirements
- R1: While reset is held and after it is released, all base registers and the interrupt vector are zero, and `rdata_o` is zero.
- R2: `rdata_o` carries the result of a selected cycle during the clock that follows it. In every other clock it is zero, and a configuration write also yields zero.
- R3: Command 4'b1010 reads doubleword 0 as {model code[31:16], maker code[15:0]}. It reads doubleword 2 as {class code[31:8], 8'h00}.
- R4: Command 4'b1011 writes to doublewords 0 and 2 are discarded, so later reads return the parameter values.
- R5: Doublewords 4 through 9 hold the six base registers, one each in ascending order. Every bit of each register can be read and written.
- R6: A configuration write updates byte k (bits 8k+7:8k) only when `be_i[k]` is 1. Bytes whose enable is 0 keep their value.
- R7: Doubleword 15 reads as {24'h0, vector}. A write there changes the vector only under `be_i[0]` and ignores bytes 1 to 3.
- R8: Reads of any other doubleword (1, 3, 10 to 14, 16 to 63) return zero, and writes to them change nothing.
- R9: A configuration access with `addr_i[10:8]` nonzero addresses a missing function. A read returns zero and a write changes nothing.
- R10: A configuration access with `addr_i[1:0]` nonzero is not aligned. A read returns zero and a write changes nothing.
- R11: `addr_i[31:11]` has no effect on any configuration access.
- R12: Command 4'b0000 returns {24'h0, vector} in the following clock, whatever the address and byte enables.
- R13: Any command other than 4'b0000, 4'b1010 and 4'b1011 returns zero and leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | A transaction is presented this clock |
| cmd_i | input | 4 | Bus command code |
| addr_i | input | 32 | Address phase value |
| be_i | input | 4 | Byte enables, active high, bit k for byte k |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read or acknowledge data, valid in the clock after the request |

## Verification
Stored state is visible only through reads. A corrupted base register or vector therefore stays hidden until the next read of doubleword 4 to 9 or 15, or the next interrupt-acknowledge cycle. When that read comes, the wrong value appears on `rdata_o` exactly one clock later. A fault in decoding shows up the same way: a misrouted write, or a byte enable that leaks, stays latent until the affected address is read back. The random mix therefore follows every write with reads across the whole space. An error in the output path, such as stale data or nonzero idle data, shows up in the very next clock.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
   localparam int DW_IDX_W = 6;   // 64 doublewords = 256 bytes
   localparam int FN_LSB   = 8;
   localparam int FN_W     = 3;

   typedef enum logic [3:0] {
      CMD_INTACK = 4'b0000,
      CMD_CFG_RD = 4'b1010,
      CMD_CFG_WR = 4'b1011
   } cfg_cmd_e;

   typedef struct packed {
      logic                rd;
      logic                wr;
      logic                ack;
      logic [DW_IDX_W-1:0] dw;
   } cfg_req_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
   import cfg_space_pkg::*;
(
   input  logic        sel_i,
   input  logic [3:0]  cmd_i,
   input  logic [31:0] addr_i,
   output cfg_req_t    req_o
);
   logic aligned;
   logic func_zero;
   logic cfg_ok;

   always_comb begin
      aligned   = (addr_i[1:0] == 2'b00);
      func_zero = (addr_i[FN_LSB +: FN_W] == '0);
      cfg_ok    = sel_i && aligned && func_zero;
      req_o.rd  = cfg_ok && (cmd_i == CMD_CFG_RD);
      req_o.wr  = cfg_ok && (cmd_i == CMD_CFG_WR);
      req_o.ack = sel_i && (cmd_i == CMD_INTACK);
      req_o.dw  = addr_i[2 +: DW_IDX_W];
   end
endmodule

// File: rtl/cfg_be_reg.sv
module cfg_be_reg #(
   parameter int BYTES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [BYTES-1:0]     be_i,
   input  logic [8*BYTES-1:0]   d_i,
   output logic [8*BYTES-1:0]   q_o
);
   initial begin
      assert (BYTES >= 1 && BYTES <= 8)
         else $error("cfg_be_reg: BYTES out of range");
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            q_o[8*b +: 8] <= 8'h00;
         else if (we_i && be_i[b])
            q_o[8*b +: 8] <= d_i[8*b +: 8];
      end
   end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
   import cfg_space_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID   = 16'h0000,
   parameter logic [15:0] DEVICE_ID   = 16'h0000,
   parameter logic [23:0] CLASS_CODE  = 24'h000000,
   parameter int          NUM_BARS    = 6,
   parameter int          BAR_BASE_DW = 4,
   parameter int          VEC_DW      = 15
) (
   input  cfg_req_t              req_i,
   input  logic [32*NUM_BARS-1:0] bar_i,
   input  logic [7:0]            vec_i,
   output logic [31:0]           rd_o
);
   localparam logic [DW_IDX_W-1:0] ID_DW    = DW_IDX_W'(0);
   localparam logic [DW_IDX_W-1:0] CLASS_DW = DW_IDX_W'(2);
   localparam logic [DW_IDX_W-1:0] VEC_SEL  = DW_IDX_W'(VEC_DW);

   always_comb begin
      rd_o = '0;
      if (req_i.ack) begin
         rd_o = {24'h0, vec_i};
      end else if (req_i.rd) begin
         if (req_i.dw == ID_DW)    rd_o = {DEVICE_ID, VENDOR_ID};
         if (req_i.dw == CLASS_DW) rd_o = {CLASS_CODE, 8'h00};
         if (req_i.dw == VEC_SEL)  rd_o = {24'h0, vec_i};
         for (int i = 0; i < NUM_BARS; i++) begin
            if (req_i.dw == DW_IDX_W'(BAR_BASE_DW + i))
               rd_o = bar_i[32*i +: 32];
         end
      end
   end
endmodule

// File: rtl/cfg_space_target.sv
module cfg_space_target
   import cfg_space_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
   parameter logic [15:0] DEVICE_ID   = 16'hA712,
   parameter logic [23:0] CLASS_CODE  = 24'h070002,
   parameter int          NUM_BARS    = 6,
   parameter int          BAR_BASE_DW = 4,
   parameter int          VEC_DW      = 15
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel_i,
   input  logic [3:0]  cmd_i,
   input  logic [31:0] addr_i,
   input  logic [3:0]  be_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] rdata_o
);
   localparam int BAR_LAST_DW = BAR_BASE_DW + NUM_BARS - 1;
   localparam int DW_COUNT    = 1 << DW_IDX_W;

   initial begin
      assert (NUM_BARS >= 1 && NUM_BARS <= 6)
         else $error("cfg_space_target: NUM_BARS must be 1..6");
      assert (BAR_BASE_DW > 2 && BAR_LAST_DW < VEC_DW)
         else $error("cfg_space_target: base registers overlap fixed fields");
      assert (VEC_DW < DW_COUNT)
         else $error("cfg_space_target: vector doubleword outside space");
   end

   cfg_req_t               req;
   logic [32*NUM_BARS-1:0] bar_q;
   logic [7:0]             vec_q;
   logic [31:0]            rd_next;

   cfg_addr_decode u_dec (
      .sel_i  (sel_i),
      .cmd_i  (cmd_i),
      .addr_i (addr_i),
      .req_o  (req)
   );

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      logic hit;
      assign hit = req.wr && (req.dw == DW_IDX_W'(BAR_BASE_DW + i));
      cfg_be_reg #(.BYTES(4)) u_bar (
         .clk   (clk),
         .rst_n (rst_n),
         .we_i  (hit),
         .be_i  (be_i),
         .d_i   (wdata_i),
         .q_o   (bar_q[32*i +: 32])
      );
   end

   logic vec_hit;
   assign vec_hit = req.wr && (req.dw == DW_IDX_W'(VEC_DW));

   cfg_be_reg #(.BYTES(1)) u_vec (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (vec_hit),
      .be_i  (be_i[0]),
      .d_i   (wdata_i[7:0]),
      .q_o   (vec_q)
   );

   cfg_read_mux #(
      .VENDOR_ID   (VENDOR_ID),
      .DEVICE_ID   (DEVICE_ID),
      .CLASS_CODE  (CLASS_CODE),
      .NUM_BARS    (NUM_BARS),
      .BAR_BASE_DW (BAR_BASE_DW),
      .VEC_DW      (VEC_DW)
   ) u_mux (
      .req_i (req),
      .bar_i (bar_q),
      .vec_i (vec_q),
      .rd_o  (rd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_o <= '0;
      else        rdata_o <= rd_next;
   end

   // R2
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> (rdata_o == 32'h0));

   // R12
   intack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && cmd_i == CMD_INTACK) |=> (rdata_o == {24'h0, $past(vec_q)}));

   // R13
   bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && cmd_i != CMD_CFG_WR) |=> ($stable(bar_q) && $stable(vec_q)));

   // R9
   func_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && cmd_i == CMD_CFG_RD && addr_i[FN_LSB +: FN_W] != '0)
      |=> (rdata_o == 32'h0));

   // R10
   misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && cmd_i != CMD_INTACK && addr_i[1:0] != 2'b00)
      |=> ($stable(bar_q) && rdata_o == 32'h0));
endmodule

// File: tb/cfg_space_target_bench.sv
`timescale 1ns/1ps
module cfg_space_target_bench;
   localparam logic [15:0] VEN = 16'h1D0F;
   localparam logic [15:0] DEV = 16'hA712;
   localparam logic [23:0] CLS = 24'h070002;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_i = 1'b0;
   logic [3:0]  cmd_i = 4'h0;
   logic [31:0] addr_i = '0;
   logic [3:0]  be_i = 4'h0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] bar_m [6];
   logic [7:0]  vec_m;

   always #10 clk = ~clk;

   cfg_space_target #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_CODE(CLS))
   u_cfg_space_target (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .cmd_i(cmd_i),
      .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [3:0] cmd, input logic [31:0] addr);
      logic [5:0] dw;
      dw = addr[7:2];
      if (cmd == 4'b0000) return {24'h0, vec_m};
      if (cmd != 4'b1010 || addr[1:0] != 2'b00 || addr[10:8] != 3'd0) return 32'h0;
      if (dw == 6'd0)  return {DEV, VEN};
      if (dw == 6'd2)  return {CLS, 8'h00};
      if (dw == 6'd15) return {24'h0, vec_m};
      if (dw >= 6'd4 && dw <= 6'd9) return bar_m[int'(dw) - 4];
      return 32'h0;
   endfunction

   function automatic string tag_of(input logic [3:0] cmd, input logic [31:0] addr);
      if (cmd == 4'b0000) return "R12";
      if (cmd != 4'b1010 && cmd != 4'b1011) return "R13";
      if (addr[1:0] != 2'b00) return "R10";
      if (addr[10:8] != 3'd0) return "R9";
      if (addr[7:2] >= 6'd4 && addr[7:2] <= 6'd9) return "R5";
      if (addr[7:2] == 6'd15) return "R7";
      if (addr[7:2] == 6'd0 || addr[7:2] == 6'd2) return "R3";
      return "R8";
   endfunction

   task automatic model_wr(input logic [3:0] cmd, input logic [31:0] addr,
                           input logic [3:0] be, input logic [31:0] wd);
      int dw;
      if (cmd != 4'b1011 || addr[1:0] != 2'b00 || addr[10:8] != 3'd0) return;
      dw = int'(addr[7:2]);
      if (dw >= 4 && dw <= 9)
         for (int k = 0; k < 4; k++)
            if (be[k]) bar_m[dw-4][8*k +: 8] = wd[8*k +: 8];
      if (dw == 15 && be[0]) vec_m = wd[7:0];
   endtask

   // Drive at a falling edge, sample the result at the next falling edge.
   task automatic xact(input logic [3:0] cmd, input logic [31:0] addr,
                       input logic [3:0] be, input logic [31:0] wd, input string req);
      logic [31:0] e;
      e = exp_rd(cmd, addr);
      sel_i = 1'b1; cmd_i = cmd; addr_i = addr; be_i = be; wdata_i = wd;
      @(negedge clk);
      model_wr(cmd, addr, be, wd);
      check(req, rdata_o, e);
   endtask

   task automatic idle(input string req);
      sel_i = 1'b0; cmd_i = $urandom_range(15, 0); addr_i = $urandom();
      @(negedge clk);
      check(req, rdata_o, 32'h0);
   endtask

   task automatic rd(input logic [5:0] dw, input string req);
      xact(4'b1010, {24'h0, dw, 2'b00}, 4'h0, 32'h0, req);
   endtask

   task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d, input string req);
      xact(4'b1011, {24'h0, dw, 2'b00}, be, d, req);
   endtask

   initial begin : watchdog
      #(20ns * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h0C0F_FEE5));
      for (int i = 0; i < 6; i++) bar_m[i] = '0;
      vec_m = '0;
      sel_i = 1'b1; cmd_i = 4'b1011; addr_i = 32'h10; be_i = 4'hF; wdata_i = '1;
      repeat (3) @(negedge clk);
      check("R1", rdata_o, 32'h0);
      rst_n = 1'b1; sel_i = 1'b0;
      @(negedge clk);
      check("R1", rdata_o, 32'h0);
      for (int i = 4; i <= 9; i++) rd(6'(i), "R1");
      xact(4'b0000, 32'h0, 4'h0, 32'h0, "R1");

      // identification and read-only protection
      rd(6'd0, "R3");
      rd(6'd2, "R3");
      wr(6'd0, 4'hF, 32'hFFFF_FFFF, "R4");
      wr(6'd2, 4'hF, 32'h1234_5678, "R4");
      rd(6'd0, "R4");
      rd(6'd2, "R4");

      // base registers, full and partial
      for (int i = 4; i <= 9; i++) wr(6'(i), 4'hF, 32'hA5A5_0000 | 32'(i), "R5");
      for (int i = 4; i <= 9; i++) rd(6'(i), "R5");
      wr(6'd5, 4'b0101, 32'h1122_3344, "R6");
      rd(6'd5, "R6");
      wr(6'd6, 4'b0000, 32'hDEAD_BEEF, "R6");
      rd(6'd6, "R6");
      idle("R2");
      idle("R2");

      // vector
      wr(6'd15, 4'b1110, 32'hFFFF_FF77, "R7");
      rd(6'd15, "R7");
      wr(6'd15, 4'b1111, 32'hFFFF_FF3C, "R7");
      rd(6'd15, "R7");
      xact(4'b0000, 32'hFFFF_FFFF, 4'hF, 32'h0, "R12");

      // unimplemented, wrong function, misaligned, upper bits, other commands
      wr(6'd1, 4'hF, 32'h5555_5555, "R8");
      rd(6'd1, "R8");
      rd(6'd12, "R8");
      rd(6'd63, "R8");
      xact(4'b1011, 32'h0000_0310, 4'hF, 32'hCAFE_0001, "R9");
      xact(4'b1010, 32'h0000_0310, 4'h0, 32'h0, "R9");
      rd(6'd4, "R9");
      xact(4'b1011, 32'h0000_0012, 4'hF, 32'hCAFE_0002, "R10");
      xact(4'b1010, 32'h0000_0011, 4'h0, 32'h0, "R10");
      rd(6'd4, "R10");
      xact(4'b1011, 32'hFFFF_F81C, 4'hF, 32'h0BAD_F00D, "R11");
      xact(4'b1010, 32'h8000_081C, 4'h0, 32'h0, "R11");
      xact(4'b0111, 32'h0000_0020, 4'hF, 32'hFFFF_FFFF, "R13");
      xact(4'b0110, 32'h0000_0020, 4'hF, 32'h0, "R13");
      rd(6'd8, "R13");
      xact(4'b1011, 32'h0000_003C, 4'h1, 32'h0000_0081, "R7");
      xact(4'b0000, 32'h0, 4'h0, 32'h0, "R12");

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic [3:0]  c;
         logic [31:0] a;
         int          pick;
         pick = $urandom_range(9, 0);
         c = (pick < 4) ? 4'b1010 : (pick < 7) ? 4'b1011 : (pick == 7) ? 4'b0000
             : 4'($urandom_range(15, 0));
         a = $urandom();
         a[7:2] = ($urandom_range(3, 0) != 0) ? 6'($urandom_range(15, 0)) : a[7:2];
         if ($urandom_range(7, 0) != 0) a[10:8] = 3'd0;
         if ($urandom_range(7, 0) != 0) a[1:0] = 2'b00;
         if ($urandom_range(9, 0) == 0) idle("R2");
         else xact(c, a, 4'($urandom_range(15, 0)), $urandom(), tag_of(c, a));
      end
      for (int i = 4; i <= 9; i++) rd(6'(i), "R5");
      rd(6'd15, "R7");

      sel_i = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule